// File: doc/BRIEF.md
# APB Transfer Phase Monitor

This block watches one APB link between a manager and a single subordinate, drives nothing onto the bus, and reports protocol breaches. On every rising clock edge it samples select, enable, address, direction, write data and ready. A small state machine uses those samples to follow the transfer through its idle, setup and access phases.

At the setup cycle the monitor takes a copy of the address, the direction and the write data. In every later access cycle it compares the live bus with that copy until ready finishes the transfer. Each kind of breach sets its own sticky flag, which stays set until a synchronous clear or a reset. Each completed transfer gives a one-cycle pulse and advances a running count.

The state machine has three states. PH_IDLE means no transfer is open. PH_SETUP means the last sampled cycle was a setup cycle. PH_WAIT means the last sampled cycle was an access cycle with ready low. The named transitions are as follows:
- open: PH_IDLE to PH_SETUP on a setup signature (select high, enable low).
- re-setup: PH_SETUP to PH_SETUP, or PH_WAIT to PH_SETUP, when a further setup signature arrives.
- stall: PH_SETUP or PH_WAIT to PH_WAIT on an access cycle with ready low.
- finish: PH_SETUP or PH_WAIT to PH_IDLE on an access cycle with ready high.
- drop: PH_SETUP or PH_WAIT to PH_IDLE when select goes low.

Top module: `apb_phase_monitor`

## Requirements
- R1: After a cycle with `rst_n` low, all flags, `xfer_done` and `xfer_count` read zero, and the monitor is in PH_IDLE.
- R2: An access cycle (select and enable high) with ready high that follows a setup cycle or a wait state completes a transfer. In the next cycle `xfer_done` is high for exactly one cycle and `xfer_count` is one higher.
- R3: An access cycle with ready low is a wait state. It gives no completion pulse, and the transfer completes at the first later access cycle with ready high.
- R4: A cycle with select and enable both high that is neither preceded by a setup cycle nor part of an open access phase sets `err_skip`.
- R5: A setup-signature cycle that directly follows another setup cycle sets `err_repeat`. The monitor then recaptures the bus values and treats the new cycle as the setup.
- R6: During an open transfer, `err_unstable` is set by any of these: the address or direction differs from its setup value in an access cycle; select drops; or enable falls during a wait state.
- R7: For a write (direction high at setup), write data that differs from its setup value in an access cycle sets `err_unstable`. For a read, write data is not compared.
- R8: Any cycle with enable high and select low sets `err_nosel`.
- R9: Each flag stays set until a cycle with `clr_err` high. A breach that falls in the same cycle as the clear still leaves its flag set.
- R10: `xfer_count` wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_err | input | 1 | Synchronous clear of all error flags |
| bus_sel | input | 1 | Subordinate select seen on the link |
| bus_enable | input | 1 | Enable (access-phase marker) seen on the link |
| bus_addr | input | ADDR_W | Address seen on the link |
| bus_write | input | 1 | Direction: 1 write, 0 read |
| bus_wdata | input | DATA_W | Write data seen on the link |
| bus_ready | input | 1 | Subordinate ready |
| xfer_done | output | 1 | One-cycle pulse per completed transfer |
| xfer_count | output | CNT_W | Completed transfers, wrapping |
| err_skip | output | 1 | Sticky: access without a setup cycle |
| err_repeat | output | 1 | Sticky: two setup cycles in a row |
| err_unstable | output | 1 | Sticky: presented access changed before completion |
| err_nosel | output | 1 | Sticky: enable high with select low |

## Verification
Every result is registered. The flags, the completion pulse and the count are all due exactly one clock after the edge that samples the offending or completing bus cycle. The bench drives inputs 1 ns after a rising edge and compares outputs 1 ns after the next rising edge, against a reference model that it advances at that same edge. A flag that must stay sticky is checked again on the idle cycles that follow. A clear is checked in the cycle right after the clear edge.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

    localparam int NUM_ERR   = 4;
    localparam int ERR_SKIP  = 0;
    localparam int ERR_RPT   = 1;
    localparam int ERR_UNST  = 2;
    localparam int ERR_NOSEL = 3;

endpackage

// File: rtl/apb_mon_shadow.sv
module apb_mon_shadow #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [DATA_W-1:0] wdata,
    output logic              mismatch
);

    logic [ADDR_W-1:0] sh_addr;
    logic              sh_write;
    logic [DATA_W-1:0] sh_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_addr  <= '0;
            sh_write <= 1'b0;
            sh_wdata <= '0;
        end else if (cap) begin
            sh_addr  <= addr;
            sh_write <= write;
            sh_wdata <= wdata;
        end
    end

    // write data only matters when the setup cycle declared a write
    always_comb begin
        mismatch = (addr != sh_addr) || (write != sh_write)
                || (sh_write && (wdata != sh_wdata));
    end

    // R6: a bus held still since the capture cycle never mismatches
    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (!$stable(addr) || !$stable(write) || !$stable(wdata) || !mismatch));

endmodule

// File: rtl/apb_mon_fsm.sv
module apb_mon_fsm
    import apb_mon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               enable,
    input  logic               ready,
    input  logic               mismatch,
    output logic               cap,
    output logic               done_ev,
    output logic [NUM_ERR-1:0] ev,
    output phase_e             phase
);

    phase_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        cap          = 1'b0;
        done_ev      = 1'b0;
        ev           = '0;
        ev[ERR_NOSEL] = enable && !sel;
        unique case (state_q)
            PH_IDLE: begin
                if (sel && !enable) begin
                    cap     = 1'b1;
                    state_d = PH_SETUP;
                end else if (sel && enable) begin
                    ev[ERR_SKIP] = 1'b1;
                end
            end
            PH_SETUP, PH_WAIT: begin
                if (sel && !enable) begin
                    if (state_q == PH_SETUP) ev[ERR_RPT]  = 1'b1;
                    else                     ev[ERR_UNST] = 1'b1;
                    cap     = 1'b1;
                    state_d = PH_SETUP;
                end else if (sel && enable) begin
                    ev[ERR_UNST] = mismatch;
                    if (ready) begin
                        done_ev = 1'b1;
                        state_d = PH_IDLE;
                    end else begin
                        state_d = PH_WAIT;
                    end
                end else begin
                    ev[ERR_UNST] = 1'b1;
                    state_d      = PH_IDLE;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    assign phase = state_q;

    // R3: a wait state is only entered from an open transfer
    p_wait_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT) |-> $past(sel && enable && !ready));

endmodule

// File: rtl/apb_mon_report.sv
module apb_mon_report
    import apb_mon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [NUM_ERR-1:0] ev,
    input  logic               done_ev,
    output logic [NUM_ERR-1:0] err,
    output logic               done,
    output logic [CNT_W-1:0]   count
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)      err[g] <= 1'b0;
            else if (ev[g])  err[g] <= 1'b1;
            else if (clr)    err[g] <= 1'b0;
        end

        // R9: a flag only falls on a clear
        p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (err[g] && !clr) |=> err[g]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            count <= '0;
        end else begin
            done <= done_ev;
            if (done_ev) count <= count + CNT_ONE;
        end
    end

    // R2 and R10: every pulse advances the count by one, modulo its width
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count == $past(count) + CNT_ONE));

    p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> $stable(count));

endmodule

// File: rtl/apb_phase_monitor.sv
module apb_phase_monitor
    import apb_mon_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_err,
    input  logic              bus_sel,
    input  logic              bus_enable,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    output logic              xfer_done,
    output logic [CNT_W-1:0]  xfer_count,
    output logic              err_skip,
    output logic              err_repeat,
    output logic              err_unstable,
    output logic              err_nosel
);

    logic               cap;
    logic               mismatch;
    logic               done_ev;
    logic [NUM_ERR-1:0] ev;
    logic [NUM_ERR-1:0] err;
    phase_e             phase;

    apb_mon_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .addr     (bus_addr),
        .write    (bus_write),
        .wdata    (bus_wdata),
        .mismatch (mismatch)
    );

    apb_mon_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel),
        .enable   (bus_enable),
        .ready    (bus_ready),
        .mismatch (mismatch),
        .cap      (cap),
        .done_ev  (done_ev),
        .ev       (ev),
        .phase    (phase)
    );

    apb_mon_report #(.CNT_W(CNT_W)) u_report (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_err),
        .ev      (ev),
        .done_ev (done_ev),
        .err     (err),
        .done    (xfer_done),
        .count   (xfer_count)
    );

    assign err_skip     = err[ERR_SKIP];
    assign err_repeat   = err[ERR_RPT];
    assign err_unstable = err[ERR_UNST];
    assign err_nosel    = err[ERR_NOSEL];

    // R8: enable without select is always flagged
    p_nosel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_enable && !bus_sel) |=> err_nosel);

    // R5: two setup signatures back to back are flagged
    p_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && bus_sel && !bus_enable) && bus_sel && !bus_enable) |=> err_repeat);

    // R4: an access with no setup and no open access phase before it
    p_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_enable && !$past(rst_n && bus_sel && !(bus_enable && bus_ready)))
        |=> err_skip);

    // R2: a completion pulse always follows a ready access cycle
    p_done_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $past(bus_sel && bus_enable && bus_ready));

    // R1: the tracker sits idle straight after reset
    p_idle_after_reset_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (phase == PH_IDLE) || !rst_n);

endmodule

// File: tb/sim_apb_phase_monitor.sv
module sim_apb_phase_monitor;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          s = 1'b0, e = 1'b0, w = 1'b0, r = 1'b0;
    logic [AW-1:0] a = '0;
    logic [DW-1:0] d = '0;
    logic          done;
    logic [CW-1:0] cnt;
    logic          f_skip, f_rpt, f_uns, f_nos;

    int checks = 0;
    int errors = 0;

    // reference model state: 0 idle, 1 setup, 2 wait
    int            m_st = 0;
    logic [AW-1:0] m_a = '0;
    logic          m_w = 1'b0;
    logic [DW-1:0] m_d = '0;
    logic          x_done = 1'b0;
    logic [CW-1:0] x_cnt = '0;
    logic          x_skip = 1'b0, x_rpt = 1'b0, x_uns = 1'b0, x_nos = 1'b0;

    always #2 clk = ~clk;

    apb_phase_monitor #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_err(clr),
        .bus_sel(s), .bus_enable(e), .bus_addr(a), .bus_write(w),
        .bus_wdata(d), .bus_ready(r),
        .xfer_done(done), .xfer_count(cnt),
        .err_skip(f_skip), .err_repeat(f_rpt), .err_unstable(f_uns), .err_nosel(f_nos)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic differs(input logic [AW-1:0] aa, input logic ww,
                                     input logic [DW-1:0] dd);
        return (aa != m_a) || (ww != m_w) || (m_w && (dd != m_d));
    endfunction

    task automatic model_edge();
        logic ev_skip, ev_rpt, ev_uns, ev_nos, ev_done;
        ev_skip = 0; ev_rpt = 0; ev_uns = 0; ev_done = 0;
        ev_nos  = e && !s;
        if (m_st == 0) begin
            if (s && !e) begin m_a = a; m_w = w; m_d = d; m_st = 1; end
            else if (s && e) ev_skip = 1;
        end else begin
            if (s && !e) begin
                if (m_st == 1) ev_rpt = 1; else ev_uns = 1;
                m_a = a; m_w = w; m_d = d; m_st = 1;
            end else if (s && e) begin
                ev_uns = differs(a, w, d);
                if (r) begin ev_done = 1; m_st = 0; end
                else m_st = 2;
            end else begin
                ev_uns = 1; m_st = 0;
            end
        end
        x_skip = ev_skip | (x_skip & !clr);
        x_rpt  = ev_rpt  | (x_rpt  & !clr);
        x_uns  = ev_uns  | (x_uns  & !clr);
        x_nos  = ev_nos  | (x_nos  & !clr);
        x_done = ev_done;
        if (ev_done) x_cnt = x_cnt + 1'b1;
    endtask

    task automatic step(input logic ss, input logic ee, input logic [AW-1:0] aa,
                        input logic ww, input logic [DW-1:0] dd, input logic rr,
                        input logic cc);
        s = ss; e = ee; a = aa; w = ww; d = dd; r = rr; clr = cc;
        @(posedge clk);
        model_edge();
        #1;
        chk("R2", "xfer_done", done, x_done);
        chk("R2", "xfer_count", cnt, x_cnt);
        chk("R4", "err_skip", f_skip, x_skip);
        chk("R5", "err_repeat", f_rpt, x_rpt);
        chk("R6", "err_unstable", f_uns, x_uns);
        chk("R8", "err_nosel", f_nos, x_nos);
    endtask

    task automatic idle(input logic cc);
        step(0, 0, '0, 0, '0, 0, cc);
    endtask

    task automatic xfer(input logic [AW-1:0] aa, input logic ww, input logic [DW-1:0] dd,
                        input int waits);
        step(1, 0, aa, ww, dd, 0, 0);
        for (int i = 0; i < waits; i++) step(1, 1, aa, ww, dd, 0, 0);
        step(1, 1, aa, ww, dd, 1, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "done", done, 0);
        chk("R1", "count", cnt, 0);
        chk("R1", "flags", {f_skip, f_rpt, f_uns, f_nos}, 0);
        rst_n = 1'b1;
        idle(0);

        // R2: write without waits
        xfer(8'h10, 1, 16'hAAAA, 0);
        chk("R2", "pulse after completion", done, 1);
        idle(0);
        chk("R2", "pulse lasts one cycle", done, 0);

        // R3: read with two wait states
        step(1, 0, 8'h20, 0, 16'h0, 0, 0);
        step(1, 1, 8'h20, 0, 16'h0, 0, 0);
        step(1, 1, 8'h20, 0, 16'h0, 0, 0);
        chk("R3", "no pulse in wait", done, 0);
        step(1, 1, 8'h20, 0, 16'h0, 1, 0);
        chk("R3", "pulse at ready", done, 1);
        chk("R3", "count after waited read", cnt, 2);

        // R7: read ignores write data changes
        step(1, 0, 8'h24, 0, 16'h1111, 0, 0);
        step(1, 1, 8'h24, 0, 16'h2222, 0, 0);
        step(1, 1, 8'h24, 0, 16'h3333, 1, 0);
        chk("R7", "read wdata ignored", f_uns, 0);
        // R7: write data change flagged
        step(1, 0, 8'h28, 1, 16'h1111, 0, 0);
        step(1, 1, 8'h28, 1, 16'h1112, 1, 0);
        chk("R7", "write wdata change", f_uns, 1);
        idle(0); idle(0);
        chk("R9", "flag sticky", f_uns, 1);
        idle(1);
        chk("R9", "flag cleared", f_uns, 0);

        // R6: address change in a wait state
        step(1, 0, 8'h30, 0, 16'h0, 0, 0);
        step(1, 1, 8'h30, 0, 16'h0, 0, 0);
        step(1, 1, 8'h34, 0, 16'h0, 1, 0);
        chk("R6", "address change", f_uns, 1);
        idle(1);
        // R6: select dropped after setup
        step(1, 0, 8'h30, 0, 16'h0, 0, 0);
        idle(0);
        chk("R6", "select dropped", f_uns, 1);
        idle(1);

        // R4: access with no setup
        step(1, 1, 8'h40, 0, 16'h0, 1, 0);
        chk("R4", "skipped setup", f_skip, 1);
        chk("R4", "no completion", done, 0);
        idle(1);

        // R5: repeated setup
        step(1, 0, 8'h44, 1, 16'h5, 0, 0);
        step(1, 0, 8'h48, 1, 16'h6, 0, 0);
        chk("R5", "repeat setup", f_rpt, 1);
        step(1, 1, 8'h48, 1, 16'h6, 1, 0);
        chk("R5", "recaptured setup", f_uns, 0);
        idle(1);

        // R8: enable without select
        step(0, 1, 8'h0, 0, 16'h0, 0, 0);
        chk("R8", "enable without select", f_nos, 1);
        // R9: a breach in the clear cycle wins
        step(0, 1, 8'h0, 0, 16'h0, 0, 1);
        chk("R9", "set beats clear", f_nos, 1);
        idle(1);
        chk("R9", "cleared", f_nos, 0);

        // R10: count wraps after 16 transfers
        begin
            logic [CW-1:0] base;
            base = cnt;
            for (int i = 0; i < 16; i++) xfer(8'h50, 0, 16'h0, 0);
            chk("R10", "count wrapped", cnt, base);
        end

        // random mix of legal transfers and arbitrary bus patterns
        for (int i = 0; i < 1500; i++) begin
            if ($urandom % 2 == 0) begin
                xfer(($urandom % 2) ? 8'h10 : 8'h14, 1'($urandom % 2),
                     ($urandom % 2) ? 16'h1 : 16'h2, int'($urandom % 3));
            end else begin
                step(1'($urandom % 4 != 0), 1'($urandom % 2),
                     ($urandom % 2) ? 8'h10 : 8'h14, 1'($urandom % 2),
                     ($urandom % 3 == 0) ? 16'h1 : 16'h2, 1'($urandom % 2),
                     1'($urandom % 16 == 0));
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule